// File: doc/BRIEF.md
# DMA Burst Planner

This block sits between a descriptor-driven DMA engine and a bus master. The engine hands it one transfer at a time: a start address, a total beat count and a direction (transmit or receive). The planner cuts the transfer into a sequence of bus burst commands and offers each one on a valid/ready command port. Each command carries a start address and a beat count. It tracks the beats still to be covered and pulses `done` when none are left. Addresses are counted in beats.

Burst size comes from a 32-bit control word. That word holds a transmit burst length and a receive burst length, an option to scale both by eight, and an option that lets receive use its own length. Two alignment bits shape the command sequence. One requires bursts to respect power-of-two boundaries. The other chooses between shortening the first burst and rounding every burst down to a boundary. A self-clearing software-reset bit puts the block back into its reset state.

Top module: `dbp_burst_planner`

## Requirements
- R1: The control word resets to 0x0002_0101 and holds these fields. Bit 0 is soft reset. Bits 13:8 are the transmit length. Bit 16 is fixed-burst. Bits 22:17 are the receive length. Bit 23 is the separate-length enable. Bit 24 is the ×8 multiplier. Bit 25 is the align enable. Every other bit reads 0.
- R2: A write with bit 0 set loads the reset value, aborts any transfer and holds bit 0 high for one cycle. In that cycle writes are ignored, `cmd_valid` and `req_ready` are low, and bit 0 then clears by itself.
- R3: The effective length L is the selected length field, with a field of 0 read as 1. When bit 24 is set, L is multiplied by 8.
- R4: With bit 23 clear, both directions use the transmit field. With bit 23 set, a receive request (`req_dir`=1) uses the receive field.
- R5: With bit 25 clear, every command has min(L, remaining) beats, and each command starts where the previous one ended.
- R6: With bit 25 set and bit 16 clear, let G be the largest power of two not above L. Every command then has min(remaining, G − (addr mod G)) beats. Only the first command may start off a boundary.
- R7: With bit 25 and bit 16 both set, every command address is the current address rounded down to a multiple of G. The command has min(G, offset + remaining) beats and covers (beats − offset) of the remaining beats.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr` and `cmd_beats` hold still.
- R9: `req_ready` is high only when the block is idle and not in soft reset. `done` pulses for one cycle after the handshake of the last command. A request of 0 beats produces no command and a `done` pulse on the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Current control word |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Planner can accept a request |
| req_dir | input | 1 | 0 transmit, 1 receive |
| req_addr | input | AW | Transfer start address in beats |
| req_beats | input | BW | Transfer length in beats |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Burst command accepted |
| cmd_dir | output | 1 | Direction of the current transfer |
| cmd_addr | output | AW | Burst start address |
| cmd_beats | output | LW | Burst beat count |
| done | output | 1 | One-cycle pulse when the transfer is covered |

## Verification
The bench sweeps length values 0, 1, 3 and 4 against a fixed receive length, in both directions, with every combination of the multiplier, separate-length and both alignment bits. Start addresses sit on a boundary or off it, and lengths of 0, 1, 9 and 40 beats produce single-burst, short-tail and many-burst sequences. A design that took a 0 length as 0 would stall or emit empty commands, and one that ignored the separate-length bit would size receive bursts from the wrong field. One that aligned every burst, or none, in the split mode would get the first or the later command counts wrong. One that forgot the leading offset in the rounded mode would lose beats or never finish. Stalls on `cmd_ready` every third cycle test whether commands hold still. An abort in the middle of a transfer tests whether soft reset clears itself after one cycle, drops the pending command and ignores a write made during that cycle.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  localparam int CTL_W   = 32;
  localparam int PBL_W   = 6;

  // control word field positions
  localparam int SWR_BIT = 0;
  localparam int TXL_LO  = 8;
  localparam int FIX_BIT = 16;
  localparam int RXL_LO  = 17;
  localparam int SEP_BIT = 23;
  localparam int X8_BIT  = 24;
  localparam int AAL_BIT = 25;

  localparam logic [CTL_W-1:0] CTL_RST   = 32'h0002_0101;
  localparam logic [CTL_W-1:0] CTL_WMASK = 32'h03FF_3F00;

  // effective burst length: zero field counts as one, optional x8
  function automatic logic [31:0] eff_len(input logic [PBL_W-1:0] pbl, input logic x8);
    logic [31:0] base;
    base = (pbl == '0) ? 32'd1 : 32'(pbl);
    return x8 ? (base << 3) : base;
  endfunction

  // largest power of two not above v (v >= 1)
  function automatic logic [31:0] pow2_floor(input logic [31:0] v);
    logic [31:0] r;
    r = 32'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = 32'd1 << i;
    end
    return r;
  endfunction

  function automatic logic [31:0] align_off(input logic [31:0] addr, input logic [31:0] gran);
    return addr & (gran - 32'd1);
  endfunction

  function automatic logic [31:0] min32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // address placed on the command port
  function automatic logic [31:0] burst_addr(input logic aal, input logic fix,
                                              input logic [31:0] gran, input logic [31:0] addr);
    return (aal && fix) ? (addr - align_off(addr, gran)) : addr;
  endfunction

  // beat count placed on the command port
  function automatic logic [31:0] burst_beats(input logic aal, input logic fix,
                                               input logic [31:0] len, input logic [31:0] gran,
                                               input logic [31:0] addr, input logic [31:0] rem);
    logic [31:0] off;
    off = align_off(addr, gran);
    if (!aal)      return min32(len, rem);
    else if (fix)  return min32(gran, off + rem);
    else           return min32(gran - off, rem);
  endfunction

  // remaining beats covered by the command
  function automatic logic [31:0] burst_used(input logic aal, input logic fix,
                                              input logic [31:0] len, input logic [31:0] gran,
                                              input logic [31:0] addr, input logic [31:0] rem);
    logic [31:0] lead;
    lead = (aal && fix) ? align_off(addr, gran) : 32'd0;
    return burst_beats(aal, fix, len, gran, addr, rem) - lead;
  endfunction

endpackage

// File: rtl/dbp_ctl_regs.sv
module dbp_ctl_regs
  import dbp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTL_W-1:0]     wr_data,
  output logic [CTL_W-1:0]     ctl_q,
  output logic                 swr,
  output logic [PBL_W-1:0]     tx_pbl,
  output logic [PBL_W-1:0]     rx_pbl,
  output logic                 sep_en,
  output logic                 x8_en,
  output logic                 aal_en,
  output logic                 fix_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
    end else if (wr_en && wr_data[SWR_BIT]) begin
      ctl_q <= CTL_RST;
    end else if (ctl_q[SWR_BIT]) begin
      ctl_q[SWR_BIT] <= 1'b0;          // self-clear, writes dropped this cycle
    end else if (wr_en) begin
      ctl_q <= wr_data & CTL_WMASK;
    end
  end

  assign swr    = ctl_q[SWR_BIT];
  assign tx_pbl = ctl_q[TXL_LO +: PBL_W];
  assign rx_pbl = ctl_q[RXL_LO +: PBL_W];
  assign sep_en = ctl_q[SEP_BIT];
  assign x8_en  = ctl_q[X8_BIT];
  assign aal_en = ctl_q[AAL_BIT];
  assign fix_en = ctl_q[FIX_BIT];

endmodule

// File: rtl/dbp_len_sel.sv
module dbp_len_sel
  import dbp_pkg::*;
#(
  parameter int LW = PBL_W + 3
) (
  input  logic              dir,
  input  logic              sep_en,
  input  logic              x8_en,
  input  logic [PBL_W-1:0]  tx_pbl,
  input  logic [PBL_W-1:0]  rx_pbl,
  output logic [LW-1:0]     len,
  output logic [LW-1:0]     gran
);

  logic [PBL_W-1:0] pick;

  always_comb begin
    pick = (sep_en && dir) ? rx_pbl : tx_pbl;
    len  = LW'(eff_len(pick, x8_en));
    gran = LW'(pow2_floor(eff_len(pick, x8_en)));
  end

endmodule

// File: rtl/dbp_sequencer.sv
module dbp_sequencer
  import dbp_pkg::*;
#(
  parameter int AW = 32,
  parameter int BW = 16,
  parameter int LW = PBL_W + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           swr,
  input  logic           cfg_aal,
  input  logic           cfg_fix,
  input  logic [LW-1:0]  len,
  input  logic [LW-1:0]  gran,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_dir,
  input  logic [AW-1:0]  req_addr,
  input  logic [BW-1:0]  req_beats,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic           cmd_dir,
  output logic [AW-1:0]  cmd_addr,
  output logic [LW-1:0]  cmd_beats,
  output logic           done,
  output logic           xfer_start,
  output logic           cmd_fire,
  output logic           last_fire,
  output logic           cur_aal,
  output logic           cur_first,
  output logic [LW-1:0]  cur_gran
);

  logic           busy_q, dir_q, aal_q, fix_q, first_q, done_q;
  logic [AW-1:0]  addr_q;
  logic [BW-1:0]  rem_q;
  logic [LW-1:0]  len_q, gran_q;
  logic [BW-1:0]  used_w;

  always_comb begin
    cmd_addr  = AW'(burst_addr(aal_q, fix_q, 32'(gran_q), 32'(addr_q)));
    cmd_beats = LW'(burst_beats(aal_q, fix_q, 32'(len_q), 32'(gran_q), 32'(addr_q), 32'(rem_q)));
    used_w    = BW'(burst_used(aal_q, fix_q, 32'(len_q), 32'(gran_q), 32'(addr_q), 32'(rem_q)));
  end

  assign req_ready  = !busy_q && !swr;
  assign xfer_start = req_valid && req_ready;
  assign cmd_valid  = busy_q && !swr;
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign last_fire  = cmd_fire && (used_w >= rem_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
      dir_q   <= 1'b0;
      aal_q   <= 1'b0;
      fix_q   <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      len_q   <= LW'(1);
      gran_q  <= LW'(1);
    end else if (swr) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (xfer_start) begin
        dir_q   <= req_dir;
        addr_q  <= req_addr;
        rem_q   <= req_beats;
        len_q   <= len;
        gran_q  <= gran;
        aal_q   <= cfg_aal;
        fix_q   <= cfg_fix;
        first_q <= 1'b1;
        if (req_beats == '0) done_q <= 1'b1;
        else                 busy_q <= 1'b1;
      end else if (cmd_fire) begin
        addr_q  <= addr_q + AW'(used_w);
        rem_q   <= rem_q - used_w;
        first_q <= 1'b0;
        if (last_fire) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done      = done_q;
  assign cmd_dir   = dir_q;
  assign cur_aal   = aal_q;
  assign cur_first = first_q;
  assign cur_gran  = gran_q;

endmodule

// File: rtl/dbp_burst_planner.sv
module dbp_burst_planner
  import dbp_pkg::*;
#(
  parameter  int AW = 32,
  parameter  int BW = 16,
  localparam int LW = PBL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dir,
  input  logic [AW-1:0]     req_addr,
  input  logic [BW-1:0]     req_beats,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_dir,
  output logic [AW-1:0]     cmd_addr,
  output logic [LW-1:0]     cmd_beats,
  output logic              done
);

  logic              swr, sep_en, x8_en, aal_en, fix_en;
  logic [PBL_W-1:0]  tx_pbl, rx_pbl;
  logic [LW-1:0]     len_w, gran_w;
  logic              xfer_start, cmd_fire, last_fire, cur_aal, cur_first;
  logic [LW-1:0]     cur_gran;

  dbp_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .ctl_q   (ctl_rdata),
    .swr     (swr),
    .tx_pbl  (tx_pbl),
    .rx_pbl  (rx_pbl),
    .sep_en  (sep_en),
    .x8_en   (x8_en),
    .aal_en  (aal_en),
    .fix_en  (fix_en)
  );

  dbp_len_sel #(.LW(LW)) u_len (
    .dir    (req_dir),
    .sep_en (sep_en),
    .x8_en  (x8_en),
    .tx_pbl (tx_pbl),
    .rx_pbl (rx_pbl),
    .len    (len_w),
    .gran   (gran_w)
  );

  dbp_sequencer #(.AW(AW), .BW(BW), .LW(LW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .swr        (swr),
    .cfg_aal    (aal_en),
    .cfg_fix    (fix_en),
    .len        (len_w),
    .gran       (gran_w),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_dir    (req_dir),
    .req_addr   (req_addr),
    .req_beats  (req_beats),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_dir    (cmd_dir),
    .cmd_addr   (cmd_addr),
    .cmd_beats  (cmd_beats),
    .done       (done),
    .xfer_start (xfer_start),
    .cmd_fire   (cmd_fire),
    .last_fire  (last_fire),
    .cur_aal    (cur_aal),
    .cur_first  (cur_first),
    .cur_gran   (cur_gran)
  );

endmodule

// File: rtl/dbp_chk.sv
module dbp_chk #(
  parameter int LW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           swr_wr,
  input logic           swr,
  input logic           req_ready,
  input logic           xfer_start,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic           cmd_fire,
  input logic           last_fire,
  input logic [LW-1:0]  cmd_addr_lo,
  input logic [LW-1:0]  cmd_beats,
  input logic           done,
  input logic           cur_aal,
  input logic           cur_first,
  input logic [LW-1:0]  cur_gran
);

  localparam logic [LW-1:0] MAXL = LW'((2 ** dbp_pkg::PBL_W - 1) * 8);

  // R2
  swr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr |-> !cmd_valid && !req_ready);

  // R2
  swr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr && !swr_wr |=> !swr);

  // R3
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_beats != '0 && cmd_beats <= MAXL);

  // R6
  later_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cur_aal && !cur_first |-> (cmd_addr_lo & (cur_gran - 1'b1)) == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !swr_wr |=> cmd_valid && $stable(cmd_addr_lo) && $stable(cmd_beats));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire && !swr_wr |=> done);

  // R9
  continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !last_fire && !swr_wr |=> cmd_valid);

  // R9
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && !swr_wr |=> cmd_valid || done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

bind dbp_burst_planner dbp_chk #(.LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .swr_wr      (ctl_we && ctl_wdata[0]),
  .swr         (ctl_rdata[0]),
  .req_ready   (req_ready),
  .xfer_start  (xfer_start),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_fire    (cmd_fire),
  .last_fire   (last_fire),
  .cmd_addr_lo (cmd_addr[LW-1:0]),
  .cmd_beats   (cmd_beats),
  .done        (done),
  .cur_aal     (cur_aal),
  .cur_first   (cur_first),
  .cur_gran    (cur_gran)
);

// File: tb/test_dbp_burst_planner.sv
module test_dbp_burst_planner;

  localparam int AW = 32;
  localparam int BW = 16;
  localparam int LW = 9;
  localparam time TCK = 8ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ctl_we = 1'b0;
  logic [31:0]    ctl_wdata = '0;
  logic [31:0]    ctl_rdata;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_dir = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [BW-1:0]  req_beats = '0;
  logic           cmd_valid;
  logic           cmd_ready = 1'b0;
  logic           cmd_dir;
  logic [AW-1:0]  cmd_addr;
  logic [LW-1:0]  cmd_beats;
  logic           done;

  int checks = 0;
  int errors = 0;
  int rc = 0;

  // bench copy of the configuration
  int  c_tx = 1, c_rx = 1;
  bit  c_sep = 0, c_x8 = 0, c_aal = 0, c_fix = 0;

  always #(TCK/2) clk = ~clk;

  dbp_burst_planner #(.AW(AW), .BW(BW)) i_dbp_burst_planner (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_dir(req_dir), .req_addr(req_addr),
    .req_beats(req_beats), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dir(cmd_dir),
    .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .done(done)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int b_len(input int pbl, input bit x8);
    int p;
    p = (pbl == 0) ? 1 : pbl;
    return x8 ? p * 8 : p;
  endfunction

  function automatic int b_gran(input int l);
    int g;
    g = 1;
    while (g * 2 <= l) g = g * 2;
    return g;
  endfunction

  function automatic int b_min(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic set_cfg(input int tx, input int rx, input bit sep, input bit x8,
                         input bit aal, input bit fix);
    logic [31:0] v;
    v = (32'(tx) << 8) | (32'(fix) << 16) | (32'(rx) << 17) | (32'(sep) << 23)
      | (32'(x8) << 24) | (32'(aal) << 25);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    check("R1", "control readback", ctl_rdata, v);
    c_tx = tx; c_rx = rx; c_sep = sep; c_x8 = x8; c_aal = aal; c_fix = fix;
  endtask

  task automatic do_xfer(input bit dir, input int addr, input int beats);
    int l, g, a, r, off, ea, eb, use_n, guard;
    bit rdy, stalled;
    string md, lt;
    l  = b_len((c_sep && dir) ? c_rx : c_tx, c_x8);
    g  = b_gran(l);
    md = !c_aal ? "R5" : (c_fix ? "R7" : "R6");
    lt = !c_aal ? (c_sep ? "R4" : "R3") : md;
    @(negedge clk);
    req_valid = 1'b1; req_dir = dir; req_addr = AW'(addr); req_beats = BW'(beats);
    check("R9", "req_ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (beats == 0) begin
      check("R9", "done for empty request", done, 1);
      check("R9", "no command for empty request", cmd_valid, 0);
      return;
    end
    check("R9", "no early done", done, 0);
    a = addr; r = beats; stalled = 0; guard = 0;
    while (r > 0 && guard < 2000) begin
      guard++;
      off = a % g;
      if (!c_aal) begin
        eb = b_min(l, r); ea = a; use_n = eb;
      end else if (c_fix) begin
        ea = a - off; eb = b_min(g, off + r); use_n = eb - off;
      end else begin
        ea = a; eb = b_min(g - off, r); use_n = eb;
      end
      check(stalled ? "R8" : md, "cmd_valid", cmd_valid, 1);
      check(stalled ? "R8" : md, "cmd_addr", cmd_addr, ea);
      check(stalled ? "R8" : lt, "cmd_beats", cmd_beats, eb);
      check("R9", "done low mid-transfer", done, 0);
      rdy = (rc % 3) != 1;
      rc++;
      cmd_ready = rdy;
      @(negedge clk);
      if (rdy) begin
        a = a + use_n; r = r - use_n; stalled = 0;
      end else begin
        stalled = 1;
      end
    end
    cmd_ready = 1'b0;
    check("R9", "done after last burst", done, 1);
    check("R9", "no command after last", cmd_valid, 0);
    check("R9", "ready after done", req_ready, 1);
  endtask

  initial begin
    #(TCK * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tl[4];
    int al[3];
    int bl[4];
    tl = '{0, 1, 3, 4};
    al = '{0, 3, 13};
    bl = '{0, 1, 9, 40};

    repeat (3) @(negedge clk);
    check("R1", "reset value", ctl_rdata, 32'h0002_0101);
    check("R2", "no request during reset", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "soft reset self-clears", ctl_rdata, 32'h0002_0100);
    check("R9", "ready after soft reset", req_ready, 1);

    set_cfg(0, 0, 0, 0, 0, 0);
    set_cfg(63, 63, 1, 1, 1, 1);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 32'hFFFF_FFFE;
    @(negedge clk);
    ctl_we = 1'b0;
    check("R1", "undefined bits read zero", ctl_rdata, 32'h03FF_3F00);

    // main sweep
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 2; s++)
        for (int x = 0; x < 2; x++)
          for (int aa = 0; aa < 2; aa++)
            for (int f = 0; f < 2; f++) begin
              set_cfg(tl[i], 6, s[0], x[0], aa[0], f[0]);
              for (int d = 0; d < 2; d++)
                for (int ai = 0; ai < 3; ai++)
                  for (int bi = 0; bi < 4; bi++)
                    do_xfer(d[0], al[ai], bl[bi]);
            end

    // soft reset in the middle of a transfer
    set_cfg(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_dir = 1'b0; req_addr = 32'd100; req_beats = 16'd20;
    @(negedge clk);
    req_valid = 1'b0; cmd_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmd_ready = 1'b0;
    check("R2", "transfer running before abort", cmd_valid, 1);
    ctl_we = 1'b1; ctl_wdata = 32'h0000_0001;
    @(negedge clk);
    check("R2", "reset value loaded", ctl_rdata, 32'h0002_0101);
    check("R2", "command dropped", cmd_valid, 0);
    check("R2", "request blocked", req_ready, 0);
    ctl_wdata = 32'h0100_0000;
    @(negedge clk);
    ctl_we = 1'b0;
    check("R2", "write ignored, bit 0 cleared", ctl_rdata, 32'h0002_0100);
    check("R2", "idle after abort", cmd_valid, 0);
    check("R2", "no done after abort", done, 0);
    c_tx = 1; c_rx = 1; c_sep = 0; c_x8 = 0; c_aal = 0; c_fix = 0;
    do_xfer(1'b0, 7, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule